// File: doc/BRIEF.md
# Serial Clock Prescaler with Selectable Divider Encoding

This block derives serial-clock timing for a SPI master from the core clock. It reads an 8-bit divider field from configuration and turns it into a divisor D. It then produces a square serial clock level together with one-cycle pulses at each of its edges. These pulses run only while a transfer is in progress. Shift-register logic elsewhere uses the rising and falling pulses to launch and capture bits. Clock polarity and phase are applied outside this block, so the level produced here always idles low.

A static parameter selects one of two field encodings. The compact encoding gives even divisors from 4 to 30. The wide encoding multiplies a 4-bit linear factor by a power of two. The 3-bit exponent of that power is spread over non-adjacent field bits, which reaches divisors up to 1920. Software is responsible for choosing the field value that best fits a wanted bit rate.

A three-state machine drives the timing. Its states are ST_IDLE (no transfer, serial clock low), ST_LOW (low phase) and ST_HIGH (high phase). ST_IDLE moves to ST_LOW when the transfer flag is seen high. ST_LOW moves to ST_HIGH at the end of the low phase. ST_HIGH moves back to ST_LOW at the end of the high phase. Both ST_LOW and ST_HIGH return to ST_IDLE as soon as the transfer flag is seen low. The divisor is captured on every cycle spent in ST_IDLE, so it is frozen for the whole transfer.

Top module: `spi_presc_gen`

## Requirements
- R1: During and right after reset, `sck_level` is 0 and `rise_tick`, `fall_tick` and `edge_tick` are 0.
- R2: While `xfer_active` is low, no tick is produced and `sck_level` stays 0, whatever `div_field` holds.
- R3: With EXTENDED=0, D = 2 × `div_field[3:0]`, and values that come out below 4 become 4 (so D is 4..30). Bits 7:4 of the field have no effect.
- R4: With EXTENDED=1, D = F × 2^E. F is `div_field[3:0]`. E is a 3-bit value whose bit 0 is `div_field[4]` and whose bits 2:1 are `div_field[7:6]`. `div_field[5]` has no effect.
- R5: With EXTENDED=1, a linear factor F of 0 acts as 1.
- R6: A computed divisor below MIN_DIV (default 4) is raised to MIN_DIV.
- R7: Let cycle k=0 be the first cycle after the clock edge that sees `xfer_active` high. In each period of D cycles, `sck_level` is 0 for the first ceil(D/2) cycles and 1 for the remaining floor(D/2) cycles, so an odd D gives the spare cycle to the low phase.
- R8: `rise_tick` is high exactly in the last cycle of each low phase, and `fall_tick` exactly in the last cycle of each high phase. `edge_tick` is their OR, and the two are never high together.
- R9: A change of `div_field` during a transfer has no effect until the next transfer begins.
- R10: One cycle after `xfer_active` is seen low, `sck_level` is 0 with no tick. A following transfer starts with a full low phase.
- R11: With EXTENDED=1, field value 0xDF gives the largest divisor, 1920.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | High while a transfer is in progress |
| div_field | input | 8 | Divider field from configuration |
| sck_level | output | 1 | Serial clock level (idles low) |
| rise_tick | output | 1 | One-cycle pulse in the cycle before the serial clock rises |
| fall_tick | output | 1 | One-cycle pulse in the cycle before the serial clock falls |
| edge_tick | output | 1 | Pulse at either serial clock edge |

## Verification
The phase counter and the latched divisor cannot be observed directly. A fault in either shows up at the ports as a wrong period or a wrong duty split. That error appears within one serial-clock period, at most 1920 cycles, of the start of a transfer. For this reason the bench compares `sck_level` and both ticks cycle by cycle against a waveform computed from the field value. A state register stuck outside ST_IDLE shows up in the first cycle after the transfer flag falls, as a high level or a stray tick. A divisor that is latched too often shows up as a period change after a mid-transfer field write.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sck_state_e;

endpackage

// File: rtl/spi_presc_decode.sv
// Turns the divider field into a divisor for the selected encoding.
module spi_presc_decode #(
    parameter bit EXTENDED = 1'b1,
    parameter int DIV_W    = 11,
    parameter int MIN_DIV  = 4
) (
    input  logic [7:0]       field,
    output logic [DIV_W-1:0] divisor
);

    localparam logic [DIV_W-1:0] FLOOR_DIV = DIV_W'(MIN_DIV);

    logic [DIV_W-1:0] raw_div;

    generate
        if (EXTENDED) begin : g_wide
            logic [3:0] lin_f;
            logic [2:0] pow_e;
            logic       unused_gap;
            always_comb begin
                lin_f   = (field[3:0] == 4'd0) ? 4'd1 : field[3:0];
                pow_e   = {field[7:6], field[4]};
                raw_div = DIV_W'(lin_f) << pow_e;
            end
            assign unused_gap = field[5];
        end else begin : g_compact
            logic unused_hi;
            always_comb begin
                raw_div = DIV_W'({field[3:0], 1'b0});
            end
            assign unused_hi = ^field[7:4];
        end
    endgenerate

    always_comb begin
        divisor = (raw_div < FLOOR_DIV) ? FLOOR_DIV : raw_div;
    end

endmodule

// File: rtl/spi_presc_phase_ctr.sv
// Counts cycles within a serial-clock phase and flags the last cycle.
module spi_presc_phase_ctr #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] last,
    output logic         at_end
);

    logic [W-1:0] cnt;

    assign at_end = (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_presc_gen.sv
module spi_presc_gen #(
    parameter bit EXTENDED = 1'b1,
    parameter int DIV_W    = 11,
    parameter int MIN_DIV  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_active,
    input  logic [7:0] div_field,
    output logic       sck_level,
    output logic       rise_tick,
    output logic       fall_tick,
    output logic       edge_tick
);

    import spi_presc_pkg::*;

    sck_state_e       st, st_nx;
    logic [DIV_W-1:0] dec_div;
    logic [DIV_W-1:0] div_lat;
    logic [DIV_W-1:0] half_dn;
    logic [DIV_W-1:0] low_last;
    logic [DIV_W-1:0] high_last;
    logic [DIV_W-1:0] phase_last;
    logic             phase_end;

    spi_presc_decode #(
        .EXTENDED (EXTENDED),
        .DIV_W    (DIV_W),
        .MIN_DIV  (MIN_DIV)
    ) u_decode (
        .field   (div_field),
        .divisor (dec_div)
    );

    // Divisor follows the field only while idle; frozen during a transfer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_lat <= DIV_W'(MIN_DIV);
        end else if (st == ST_IDLE) begin
            div_lat <= dec_div;
        end
    end

    always_comb begin
        half_dn    = div_lat >> 1;
        low_last   = div_lat - half_dn - 1'b1;
        high_last  = half_dn - 1'b1;
        phase_last = (st == ST_HIGH) ? high_last : low_last;
    end

    spi_presc_phase_ctr #(
        .W (DIV_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (st == ST_IDLE),
        .last   (phase_last),
        .at_end (phase_end)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: st_nx = xfer_active ? ST_LOW : ST_IDLE;
            ST_LOW: begin
                if (!xfer_active)   st_nx = ST_IDLE;
                else if (phase_end) st_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (!xfer_active)   st_nx = ST_IDLE;
                else if (phase_end) st_nx = ST_LOW;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sck_level = 1'b0;
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_LOW:  rise_tick = phase_end;
            ST_HIGH: begin
                sck_level = 1'b1;
                fall_tick = phase_end;
            end
            default: ;
        endcase
        edge_tick = rise_tick | fall_tick;
    end

endmodule

// File: rtl/spi_presc_gen_chk.sv
module spi_presc_gen_chk #(
    parameter int DIV_W   = 11,
    parameter int MIN_DIV = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    xfer_active,
    input logic                    sck_level,
    input logic                    rise_tick,
    input logic                    fall_tick,
    input logic                    edge_tick,
    input spi_presc_pkg::sck_state_e st,
    input logic [DIV_W-1:0]        div_lat
);

    import spi_presc_pkg::*;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sck_level && !edge_tick));

    a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> (!sck_level && !edge_tick));

    a_r8_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick && fall_tick));

    a_r8_rise_goes_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_tick && xfer_active) |=> sck_level);

    a_r8_fall_goes_low: assert property (@(posedge clk) disable iff (!rst_n)
        fall_tick |=> !sck_level);

    a_r7_level_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !edge_tick) |=> $stable(sck_level));

    a_r9_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && xfer_active) |=> $stable(div_lat));

    a_r6_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> (div_lat >= DIV_W'(MIN_DIV)));

endmodule

bind spi_presc_gen spi_presc_gen_chk #(
    .DIV_W   (DIV_W),
    .MIN_DIV (MIN_DIV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .sck_level   (sck_level),
    .rise_tick   (rise_tick),
    .fall_tick   (fall_tick),
    .edge_tick   (edge_tick),
    .st          (st),
    .div_lat     (div_lat)
);

// File: tb/spi_presc_gen_test.sv
module spi_presc_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act_e = 1'b0, act_l = 1'b0;
    logic [7:0] fld_e = 8'h00, fld_l = 8'h00;
    logic       sck_e, rise_e, fall_e, edge_e;
    logic       sck_l, rise_l, fall_l, edge_l;
    int         n_checks = 0;
    int         n_errs = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    spi_presc_gen #(.EXTENDED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .xfer_active(act_e), .div_field(fld_e),
        .sck_level(sck_e), .rise_tick(rise_e), .fall_tick(fall_e), .edge_tick(edge_e)
    );

    spi_presc_gen #(.EXTENDED(1'b0)) uut_legacy (
        .clk(clk), .rst_n(rst_n), .xfer_active(act_l), .div_field(fld_l),
        .sck_level(sck_l), .rise_tick(rise_l), .fall_tick(fall_l), .edge_tick(edge_l)
    );

    function automatic int exp_div(bit ext, logic [7:0] f);
        int d;
        if (ext) begin
            int lin;
            int pw;
            lin = (f[3:0] == 0) ? 1 : int'(f[3:0]);
            pw  = int'({f[7:6], f[4]});
            d   = lin * (1 << pw);
        end else begin
            d = 2 * int'(f[3:0]);
        end
        if (d < 4) d = 4;
        return d;
    endfunction

    task automatic sample(bit ext, output logic s, output logic r,
                          output logic fl, output logic e);
        if (ext) begin s = sck_e; r = rise_e; fl = fall_e; e = edge_e; end
        else     begin s = sck_l; r = rise_l; fl = fall_l; e = edge_l; end
    endtask

    task automatic drive(bit ext, logic a, logic [7:0] f);
        if (ext) begin act_e = a; fld_e = f; end
        else     begin act_l = a; fld_l = f; end
    endtask

    // One transfer: waveform compared every cycle against divisor of fa;
    // field switched to fb after cycle chg (no effect expected, R9).
    // Afterwards the idle cycle is checked (R10).
    task automatic run_xfer(bit ext, logic [7:0] fa, logic [7:0] fb,
                            int chg, int ncyc, string tag);
        int   d, lo, bad_k;
        logic s, r, fl, e, es, er, ef;
        d = exp_div(ext, fa);
        lo = d - d / 2;
        bad_k = -1;
        @(negedge clk);
        drive(ext, 1'b1, fa);
        for (int k = 0; k < ncyc; k++) begin
            @(posedge clk);
            @(negedge clk);
            sample(ext, s, r, fl, e);
            es = ((k % d) >= lo);
            er = ((k % d) == lo - 1);
            ef = ((k % d) == d - 1);
            if (bad_k < 0 && (s !== es || r !== er || fl !== ef || e !== (er | ef))) begin
                bad_k = k;
                $display("FAIL %s field=%02h cycle %0d: sck/rise/fall/edge=%b%b%b%b expected %b%b%b%b",
                         tag, fa, k, s, r, fl, e, es, er, ef, er | ef);
            end
            if (k == chg) drive(ext, 1'b1, fb);
        end
        n_checks++;
        if (bad_k >= 0) n_errs++;
        drive(ext, 1'b0, fb);
        @(posedge clk);
        @(negedge clk);
        sample(ext, s, r, fl, e);
        n_checks++;
        if (s !== 1'b0 || e !== 1'b0) begin
            n_errs++;
            $display("FAIL R10 stop: sck=%b edge=%b expected 0 0", s, e);
        end
    endtask

    task automatic t_reset();
        // R1
        n_checks++;
        if (sck_e !== 1'b0 || edge_e !== 1'b0 || sck_l !== 1'b0 || edge_l !== 1'b0) begin
            n_errs++;
            $display("FAIL R1 reset: sck=%b%b edge=%b%b expected 00 00", sck_e, sck_l, edge_e, edge_l);
        end
    endtask

    task automatic t_idle();
        // R2: field changes with no transfer
        int bad = 0;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            fld_e = 8'(k * 11);
            fld_l = 8'(k * 7);
            if (sck_e || edge_e || sck_l || edge_l) bad++;
        end
        n_checks++;
        if (bad != 0) begin
            n_errs++;
            $display("FAIL R2 idle: %0d active cycles expected 0", bad);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        // R3 compact encoding
        run_xfer(1'b0, 8'h10, 8'h10, -1, 20, "R3 clamp");
        run_xfer(1'b0, 8'h11, 8'h11, -1, 20, "R3 clamp");
        run_xfer(1'b0, 8'h17, 8'h17, -1, 40, "R3 mid");
        run_xfer(1'b0, 8'h1F, 8'h1F, -1, 70, "R3 max");
        run_xfer(1'b0, 8'hEF, 8'hEF, -1, 70, "R3 upper bits ignored");
        // R4 wide encoding
        run_xfer(1'b1, 8'h13, 8'h13, -1, 30, "R4 exp bit0");
        run_xfer(1'b1, 8'hC2, 8'hC2, -1, 300, "R4 exp bits2:1");
        run_xfer(1'b1, 8'h25, 8'h25, -1, 30, "R4 gap bit ignored");
        run_xfer(1'b1, 8'hC0, 8'hC0, -1, 140, "R5 zero factor");
        run_xfer(1'b1, 8'h03, 8'h03, -1, 20, "R6 floor");
        run_xfer(1'b1, 8'h05, 8'h05, -1, 25, "R7 odd");
        run_xfer(1'b1, 8'h05, 8'h07, 12, 40, "R9 mid change");
        run_xfer(1'b1, 8'h07, 8'h07, -1, 30, "R10 restart");
        run_xfer(1'b1, 8'hDF, 8'hDF, -1, 2000, "R11 max");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule